// File: doc/BRIEF.md
# Tile-Granular Weight Staging Queue

This block sits between the read path of an external, read-only weight memory and the weight-load port of a square multiply array. Weight data arrives one row at a time (a row holds N elements of ELEM_W bits) over a valid/ready stream. Rows are grouped into tiles of N rows. The queue holds up to DEPTH tiles, with a default of four. It never writes anything back toward memory. A tile counts as available only once every one of its rows has been accepted.

The array asks for a tile with a request line. It also reports through `shadow_busy` that its second (shadow) weight slot still holds a tile it has not yet swapped in. A request is granted only when three things hold: a complete tile is waiting, no burst is in progress, and the shadow slot is free. After a grant, the tile streams out as an N-cycle burst, one row per cycle. The first row is flagged with a start marker and the last row with an end marker. Because of this, loading the shadow slot overlaps with computation on the active slot. Two counts report occupancy: the number of complete tiles waiting, and the number of tile slots in use.

The reset input is asynchronous and active low. Its release is synchronised inside the block, so the internal state leaves reset two rising edges after `rst_n` goes high.

Top module: `wstage_fifo`

## Requirements
- R1: After reset, wr_ready is 1, while rd_valid, rd_first, rd_last, tile_gnt, occ_complete and occ_held are all 0.
- R2: A tile enters occ_complete in the cycle after its N-th row is accepted; a tile with fewer accepted rows is not counted there.
- R3: wr_ready is 0 exactly when the number of complete waiting tiles plus one (if a burst is in progress) equals DEPTH.
- R4: tile_gnt is 1 in a cycle exactly when tile_req is 1, occ_complete is nonzero, rd_valid is 0 and shadow_busy is 0.
- R5: rd_valid goes high in the cycle after a grant and stays high for exactly N consecutive cycles, then is low for at least one cycle; rd_row is all zeros whenever rd_valid is 0.
- R6: rd_first is 1 only on the first row of a burst and rd_last is 1 only on the N-th row.
- R7: Delivered rows equal accepted rows in acceptance order: tiles leave in arrival order, and rows within a tile leave in arrival order.
- R8: occ_complete drops by one in the cycle after a grant, unless another tile completes in the same cycle, in which case it stays unchanged.
- R9: occ_held equals occ_complete, plus 1 while a burst is in progress, plus 1 while a tile has between 1 and N-1 rows accepted.
- R10: While shadow_busy is 1, tile_req has no effect: no grant occurs and no burst starts.
- R11: A row offered while wr_ready is 0 is not stored and does not appear in any later burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Memory row valid |
| wr_row | input | N*ELEM_W | Memory row data |
| wr_ready | output | 1 | Queue can accept a row |
| tile_req | input | 1 | Array requests the next tile |
| shadow_busy | input | 1 | Array shadow slot holds an unswapped tile |
| tile_gnt | output | 1 | Request accepted this cycle |
| rd_valid | output | 1 | Burst row valid |
| rd_row | output | N*ELEM_W | Burst row data |
| rd_first | output | 1 | First row of the tile |
| rd_last | output | 1 | Last row of the tile |
| occ_complete | output | clog2(DEPTH+1) | Complete tiles waiting |
| occ_held | output | clog2(DEPTH+1) | Tile slots in use, including partial and bursting |

## Verification
The assertions assume every input carries a known value on each rising edge. They also assume the array consumes a burst row in every cycle, since the block has no back-pressure on the read side. The stimulus satisfies both assumptions. It drives all inputs only at falling edges, and it gives each of them a defined 0 or 1 every cycle, whether the value comes from a directed step or from a biased random draw. The stimulus lets tile_req and shadow_busy toggle freely, including during bursts and while the queue is full. This exercises the grant rule and the ignore-while-full rule at those edges.

// File: rtl/wstage_pkg.sv
package wstage_pkg;
  // Bit width needed to index n distinct values (at least one bit).
  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/wstage_store.sv
module wstage_store
  import wstage_pkg::*;
#(
  parameter int unsigned N     = 8,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned ROW_W = 64
) (
  input  logic                       clk,
  input  logic                       we,
  input  logic [idx_w(DEPTH)-1:0]    wtile,
  input  logic [idx_w(N)-1:0]        wrow,
  input  logic [ROW_W-1:0]           wdata,
  input  logic [idx_w(DEPTH)-1:0]    rtile,
  input  logic [idx_w(N)-1:0]        rrow,
  output logic [ROW_W-1:0]           rdata
);
  localparam int unsigned TW = idx_w(DEPTH);

  logic [ROW_W-1:0] bank_out [DEPTH];

  // One bank of N rows per tile slot; writes decode the slot index.
  for (genvar t = 0; t < DEPTH; t++) begin : g_tile
    logic [ROW_W-1:0] rows [N];
    logic             bank_we;

    assign bank_we = we && (wtile == TW'(t));

    always_ff @(posedge clk) begin
      if (bank_we) begin
        rows[wrow] <= wdata;
      end
    end

    assign bank_out[t] = rows[rrow];
  end

  assign rdata = bank_out[rtile];
endmodule

// File: rtl/wstage_fill.sv
module wstage_fill
  import wstage_pkg::*;
#(
  parameter int unsigned N     = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fire,
  output logic [idx_w(DEPTH)-1:0] tile,
  output logic [idx_w(N)-1:0]     row,
  output logic                    partial,
  output logic                    tile_done
);
  localparam int unsigned RW = idx_w(N);
  localparam int unsigned TW = idx_w(DEPTH);

  logic [RW-1:0] row_q, row_d;
  logic [TW-1:0] tile_q, tile_d;
  logic          at_end;

  assign at_end = (row_q == RW'(N - 1));

  always_comb begin
    row_d  = row_q;
    tile_d = tile_q;
    if (fire) begin
      if (at_end) begin
        row_d  = '0;
        tile_d = (tile_q == TW'(DEPTH - 1)) ? '0 : tile_q + TW'(1);
      end else begin
        row_d = row_q + RW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q  <= '0;
      tile_q <= '0;
    end else if (fire) begin
      row_q  <= row_d;
      tile_q <= tile_d;
    end
  end

  assign tile      = tile_q;
  assign row       = row_q;
  assign partial   = (row_q != '0);
  assign tile_done = fire && at_end;
endmodule

// File: rtl/wstage_drain.sv
module wstage_drain
  import wstage_pkg::*;
#(
  parameter int unsigned N     = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    gnt,
  output logic                    active,
  output logic                    first,
  output logic                    last,
  output logic [idx_w(DEPTH)-1:0] tile,
  output logic [idx_w(N)-1:0]     row
);
  localparam int unsigned RW = idx_w(N);
  localparam int unsigned TW = idx_w(DEPTH);

  logic          act_q, act_d;
  logic [RW-1:0] row_q, row_d;
  logic [TW-1:0] tile_q, tile_d;
  logic          step_en;
  logic          at_end;

  assign at_end  = (row_q == RW'(N - 1));
  assign step_en = act_q | gnt;

  always_comb begin
    act_d  = act_q;
    row_d  = row_q;
    tile_d = tile_q;
    if (act_q) begin
      if (at_end) begin
        act_d  = 1'b0;
        row_d  = '0;
        tile_d = (tile_q == TW'(DEPTH - 1)) ? '0 : tile_q + TW'(1);
      end else begin
        row_d = row_q + RW'(1);
      end
    end
    if (gnt) begin
      act_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      row_q  <= '0;
      tile_q <= '0;
    end else if (step_en) begin
      act_q  <= act_d;
      row_q  <= row_d;
      tile_q <= tile_d;
    end
  end

  assign active = act_q;
  assign first  = act_q && (row_q == '0);
  assign last   = act_q && at_end;
  assign tile   = tile_q;
  assign row    = row_q;
endmodule

// File: rtl/wstage_fifo.sv
module wstage_fifo
  import wstage_pkg::*;
#(
  parameter int unsigned N      = 8,
  parameter int unsigned ELEM_W = 8,
  parameter int unsigned DEPTH  = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_valid,
  input  logic [N*ELEM_W-1:0]           wr_row,
  output logic                          wr_ready,
  input  logic                          tile_req,
  input  logic                          shadow_busy,
  output logic                          tile_gnt,
  output logic                          rd_valid,
  output logic [N*ELEM_W-1:0]           rd_row,
  output logic                          rd_first,
  output logic                          rd_last,
  output logic [idx_w(DEPTH+1)-1:0]     occ_complete,
  output logic [idx_w(DEPTH+1)-1:0]     occ_held
);
  localparam int unsigned ROW_W = N * ELEM_W;
  localparam int unsigned RW    = idx_w(N);
  localparam int unsigned TW    = idx_w(DEPTH);
  localparam int unsigned CW    = idx_w(DEPTH + 1);

  // Reset release synchroniser.
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_i_n = rst_sync_q[1];

  logic [TW-1:0]    fill_tile, drain_tile;
  logic [RW-1:0]    fill_row, drain_row;
  logic             partial, tile_done;
  logic             deliv, d_first, d_last;
  logic             fire;
  logic [ROW_W-1:0] store_rd;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             cnt_en;
  logic [CW:0]      slots_taken;

  assign slots_taken = {1'b0, cnt_q} + (CW+1)'(deliv);
  assign wr_ready    = (slots_taken < (CW+1)'(DEPTH));
  assign fire        = wr_valid && wr_ready;
  assign tile_gnt    = tile_req && (cnt_q != '0) && !deliv && !shadow_busy;

  wstage_fill #(.N(N), .DEPTH(DEPTH)) u_fill (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .fire      (fire),
    .tile      (fill_tile),
    .row       (fill_row),
    .partial   (partial),
    .tile_done (tile_done)
  );

  wstage_drain #(.N(N), .DEPTH(DEPTH)) u_drain (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .gnt    (tile_gnt),
    .active (deliv),
    .first  (d_first),
    .last   (d_last),
    .tile   (drain_tile),
    .row    (drain_row)
  );

  wstage_store #(.N(N), .DEPTH(DEPTH), .ROW_W(ROW_W)) u_store (
    .clk   (clk),
    .we    (fire),
    .wtile (fill_tile),
    .wrow  (fill_row),
    .wdata (wr_row),
    .rtile (drain_tile),
    .rrow  (drain_row),
    .rdata (store_rd)
  );

  // Complete-tile counter.
  assign cnt_en = tile_done | tile_gnt;

  always_comb begin
    cnt_d = cnt_q;
    if (tile_done) cnt_d = cnt_d + CW'(1);
    if (tile_gnt)  cnt_d = cnt_d - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign rd_valid     = deliv;
  assign rd_first     = d_first;
  assign rd_last      = d_last;
  assign rd_row       = deliv ? store_rd : '0;
  assign occ_complete = cnt_q;
  assign occ_held     = cnt_q + CW'(deliv) + CW'(partial);
endmodule

// File: rtl/wstage_fifo_chk.sv
module wstage_fifo_chk
  import wstage_pkg::*;
#(
  parameter int unsigned N     = 8,
  parameter int unsigned DEPTH = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      wr_valid,
  input logic                      wr_ready,
  input logic                      tile_req,
  input logic                      shadow_busy,
  input logic                      tile_gnt,
  input logic                      rd_valid,
  input logic                      rd_first,
  input logic                      rd_last,
  input logic [idx_w(DEPTH+1)-1:0] occ_complete,
  input logic [idx_w(DEPTH+1)-1:0] occ_held
);
  localparam int unsigned CW = idx_w(DEPTH + 1);
  localparam int unsigned KW = idx_w(N + 1);

  // Count of consecutive valid rows seen before the current cycle.
  logic [KW-1:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (rd_valid) begin
      run_q <= run_q + KW'(1);
    end else begin
      run_q <= '0;
    end
  end

  // R4
  gnt_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tile_gnt |-> (tile_req && occ_complete != '0 && !rd_valid));

  // R10
  shadow_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shadow_busy |-> !tile_gnt);

  // R5
  burst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tile_gnt |=> (rd_valid && rd_first));

  // R5
  burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (run_q < KW'(N)));

  // R6
  last_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_last |-> (rd_valid && run_q == KW'(N - 1)));

  // R6
  first_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_first |-> (rd_valid && run_q == '0));

  // R5
  burst_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_last |=> !rd_valid);

  // R3
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_complete == CW'(DEPTH)) |-> !wr_ready);

  // R2
  complete_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && wr_ready) |=> (occ_complete <= $past(occ_complete)));

  // R9
  held_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_held >= occ_complete) && (occ_held <= occ_complete + CW'(2)));
endmodule

bind wstage_fifo wstage_fifo_chk #(.N(N), .DEPTH(DEPTH)) u_wstage_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_valid     (wr_valid),
  .wr_ready     (wr_ready),
  .tile_req     (tile_req),
  .shadow_busy  (shadow_busy),
  .tile_gnt     (tile_gnt),
  .rd_valid     (rd_valid),
  .rd_first     (rd_first),
  .rd_last      (rd_last),
  .occ_complete (occ_complete),
  .occ_held     (occ_held)
);

// File: tb/test_wstage_fifo.sv
module test_wstage_fifo;
  localparam int CLK_P = 10;
  localparam int N     = 4;
  localparam int EW    = 8;
  localparam int DEPTH = 4;
  localparam int RWD   = N * EW;
  localparam int CW    = 3;

  logic           clk;
  logic           rst_n;
  logic           wr_valid;
  logic [RWD-1:0] wr_row;
  logic           wr_ready;
  logic           tile_req;
  logic           shadow_busy;
  logic           tile_gnt;
  logic           rd_valid;
  logic [RWD-1:0] rd_row;
  logic           rd_first;
  logic           rd_last;
  logic [CW-1:0]  occ_complete;
  logic [CW-1:0]  occ_held;

  wstage_fifo #(.N(N), .ELEM_W(EW), .DEPTH(DEPTH)) i_wstage_fifo (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_valid     (wr_valid),
    .wr_row       (wr_row),
    .wr_ready     (wr_ready),
    .tile_req     (tile_req),
    .shadow_busy  (shadow_busy),
    .tile_gnt     (tile_gnt),
    .rd_valid     (rd_valid),
    .rd_row       (rd_row),
    .rd_first     (rd_first),
    .rd_last      (rd_last),
    .occ_complete (occ_complete),
    .occ_held     (occ_held)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  int             n_chk, n_bad;
  bit             done;
  int             mcomp, mrow, mrd;
  bit             mdeliv;
  logic [RWD-1:0] q[$];
  int unsigned    seed_dummy;

  function automatic bit exp_ready(int c, bit d);
    return (c + int'(d)) < DEPTH;
  endfunction

  function automatic bit exp_gnt(bit rq, bit bz, int c, bit d);
    return rq && (c != 0) && !d && !bz;
  endfunction

  function automatic int exp_held(int c, bit d, int r);
    return c + int'(d) + ((r != 0) ? 1 : 0);
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // One clock cycle, entered and left at a falling edge.
  task automatic cyc(input bit v, input logic [RWD-1:0] d, input bit rq, input bit bz);
    bit mg;
    bit inc;
    inc = 1'b0;
    chk(wr_ready === exp_ready(mcomp, mdeliv), "R3 wr_ready", wr_ready, exp_ready(mcomp, mdeliv));
    chk(occ_complete === CW'(mcomp), "R2 R8 occ_complete", occ_complete, mcomp);
    chk(occ_held === CW'(exp_held(mcomp, mdeliv, mrow)), "R9 occ_held", occ_held, exp_held(mcomp, mdeliv, mrow));
    chk(rd_valid === mdeliv, "R5 rd_valid", rd_valid, mdeliv);
    if (mdeliv) begin
      chk(rd_first === (mrd == 0), "R6 rd_first", rd_first, (mrd == 0));
      chk(rd_last === (mrd == N-1), "R6 rd_last", rd_last, (mrd == N-1));
      chk((q.size() > 0) && (rd_row === q[0]), "R7 rd_row", rd_row, (q.size() > 0) ? q[0] : '0);
    end else begin
      chk(rd_row === '0, "R5 idle rd_row", rd_row, 0);
      chk(!rd_first && !rd_last, "R6 idle markers", {rd_first, rd_last}, 0);
    end
    wr_valid    = v;
    wr_row      = d;
    tile_req    = rq;
    shadow_busy = bz;
    #1;
    mg = exp_gnt(rq, bz, mcomp, mdeliv);
    chk(tile_gnt === mg, "R4 R10 tile_gnt", tile_gnt, mg);
    if (v && exp_ready(mcomp, mdeliv)) begin
      q.push_back(d);
      mrow++;
      if (mrow == N) begin
        mrow = 0;
        inc  = 1'b1;
      end
    end
    if (mdeliv) begin
      void'(q.pop_front());
      mrd++;
      if (mrd == N) begin
        mdeliv = 1'b0;
        mrd    = 0;
      end
    end
    if (mg) begin
      mdeliv = 1'b1;
      mrd    = 0;
      mcomp--;
    end
    if (inc) mcomp++;
    @(negedge clk);
  endtask

  initial begin
    done = 1'b0;
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      summary();
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0;
    mcomp = 0; mrow = 0; mrd = 0; mdeliv = 1'b0;
    seed_dummy = $urandom(32'h5eed);
    rst_n = 1'b0; wr_valid = 1'b0; wr_row = '0; tile_req = 1'b0; shadow_busy = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk(wr_ready === 1'b1, "R1 wr_ready", wr_ready, 1);
    chk(rd_valid === 1'b0 && rd_first === 1'b0 && rd_last === 1'b0, "R1 read side", {rd_valid, rd_first, rd_last}, 0);
    chk(tile_gnt === 1'b0, "R1 tile_gnt", tile_gnt, 0);
    chk(occ_complete === '0 && occ_held === '0, "R1 counts", {occ_complete, occ_held}, 0);

    // R2: partial tile is not counted
    for (int i = 0; i < N-1; i++) cyc(1'b1, RWD'(32'h1000 + i), 1'b0, 1'b0);
    chk(occ_complete === '0, "R2 partial", occ_complete, 0);
    chk(occ_held === CW'(1), "R9 partial held", occ_held, 1);
    cyc(1'b1, RWD'(32'h1000 + N - 1), 1'b0, 1'b0);
    chk(occ_complete === CW'(1), "R2 complete", occ_complete, 1);

    // R3: fill to capacity
    for (int i = 0; i < 3*N; i++) cyc(1'b1, RWD'(32'h2000 + i), 1'b0, 1'b0);
    chk(wr_ready === 1'b0, "R3 full", wr_ready, 0);
    chk(occ_complete === CW'(DEPTH), "R3 count full", occ_complete, DEPTH);

    // R11: offered rows while full are dropped
    for (int i = 0; i < 3; i++) cyc(1'b1, RWD'(32'hDEAD0000 + i), 1'b0, 1'b0);
    chk(occ_held === CW'(DEPTH), "R11 held unchanged", occ_held, DEPTH);

    // R10: request blocked by busy shadow slot
    for (int i = 0; i < 3; i++) cyc(1'b0, '0, 1'b1, 1'b1);
    chk(rd_valid === 1'b0, "R10 no burst", rd_valid, 0);
    chk(occ_complete === CW'(DEPTH), "R10 count kept", occ_complete, DEPTH);

    // R5 R6 R7 R8: drain everything
    for (int i = 0; i < DEPTH*(N+2); i++) cyc(1'b0, '0, 1'b1, 1'b0);
    chk(occ_held === '0, "R9 empty", occ_held, 0);
    chk(wr_ready === 1'b1, "R3 ready after drain", wr_ready, 1);

    // Random traffic
    for (int i = 0; i < 4000; i++) begin
      cyc(($urandom % 10) < 7, RWD'($urandom), ($urandom % 10) < 4, ($urandom % 4) == 0);
    end

    // Flush
    for (int i = 0; i < DEPTH*(N+2) + 2; i++) cyc(1'b0, '0, 1'b1, 1'b0);
    chk(occ_held === CW'(exp_held(mcomp, mdeliv, mrow)), "R9 final", occ_held, exp_held(mcomp, mdeliv, mrow));

    done = 1'b1;
    summary();
    $finish;
  end
endmodule